// File: doc/BRIEF.md
# Interrupt-Triggered Transfer Start Selector

This block decides when a single-channel transfer engine may begin a transfer. It turns one of two sources into a one-cycle start pulse. The first source is a software start strobe. The second is one request line picked from a vector of sixteen interrupt requests. A mode bit sets whether the picked line acts on its rising edge or on its level.

In automatic mode only the picked request line can start a transfer, and the software strobe has no effect. With automatic mode clear, only the strobe counts. The module enable gates every start. A busy indication from the engine also blocks any start, so a running transfer is never restarted. The request vector is registered before selection, and the selected bit is registered a second time to feed the edge detector. When the channel select or the mode bit changes, the detector holds off for one cycle so that the change itself is never read as an edge.

Top module: `irq_start_sel`

## Requirements
- R1: A select value N on `chan_sel` makes request line N, and no other line, the hardware trigger source (0 picks line 0, 15 picks line 15).
- R2: With `level_mode` = 0 and `auto_mode` = 1, a rise of the selected line that is seen at clock edge k gives exactly one `start_pulse` in the cycle after edge k+1. The line counts as having risen at edge k when it is low at edge k-1 and high at edge k. A line that stays high gives no further pulse.
- R3: With `level_mode` = 1 and `auto_mode` = 1, every clock edge k at which the selected line is sampled high gives a pulse in the cycle after edge k+1.
- R4: With `auto_mode` = 0, a `sw_start` sampled high at edge k gives a pulse in the cycle after edge k, and the request lines have no effect on `start_pulse`.
- R5: With `auto_mode` = 1, `sw_start` has no effect on `start_pulse`.
- R6: A pulse is produced only if `enable` was sampled high at the edge that computes it.
- R7: A pulse is produced only if `eng_busy` was sampled low at the edge that computes it. A trigger blocked this way is dropped and not kept for later.
- R8: In edge mode, an edge at which `chan_sel` or `level_mode` differs from its value at the previous edge produces no edge trigger. Selecting a line that is already high therefore never starts a transfer.
- R9: `start_pulse` is 0 while `rst_n` is low and in the first cycle after reset is released, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 16 | Interrupt request lines, bit i is line i |
| chan_sel | input | 4 | Index of the request line used as trigger |
| level_mode | input | 1 | 0: trigger on rising edge, 1: trigger while high |
| auto_mode | input | 1 | 1: request line starts transfers, 0: software strobe starts them |
| enable | input | 1 | Module enable; no start while low |
| sw_start | input | 1 | Software start strobe |
| eng_busy | input | 1 | Engine reports a transfer in progress |
| start_pulse | output | 1 | One-cycle start request to the engine |

## Verification
The edge detector's previous-value register and the stored copy of the configuration are the only hidden state. An error in either shows at the port as a missing pulse or an extra pulse. The error becomes visible two cycles after the disturbing rise or configuration change, and no later. In level mode a wrong selection shows on the first high cycle of the wrong line, because every high cycle must pulse. Random stimulus sweeps channel switches while lines are high, mode flips, busy and enable gating, and strobes in both modes. A reference model rebuilt from the timing rules above checks every cycle. Directed sequences pin down the held-line single pulse, the pulse count in level mode and the release from reset.

// File: rtl/irq_start_sel_pkg.sv
// Shared definitions for the interrupt-triggered start selector.
// Assumes the number of request lines is a power of two.
package irq_start_sel_pkg;
    localparam int DEF_LINES = 16;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;
endpackage

// File: rtl/req_capture.sv
// Registers the whole request vector once before any selection.
// Assumes requests are already synchronous to clk.
module req_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_i,
    output logic [W-1:0] req_q
);
    // sample every request line once per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_i;
    end
endmodule

// File: rtl/line_picker.sv
// Selects one registered request line and detects its rising edge.
// Holds the edge off for one cycle after the select or mode changes.
// Assumes LINES is a power of two, so every select value is in range.
module line_picker
    import irq_start_sel_pkg::*;
#(
    parameter int LINES = DEF_LINES,
    localparam int SEL_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req_q,
    input  logic [SEL_W-1:0] sel_i,
    input  trig_mode_e       mode_i,
    output logic             line_o,
    output logic             edge_o
);
    logic             prev_q;
    logic [SEL_W-1:0] sel_q;
    trig_mode_e       mode_q;
    logic             cfg_moved;

    // pick the configured line from the captured vector
    always_comb line_o = req_q[sel_i];

    // configuration differs from the one seen at the last edge
    always_comb cfg_moved = (sel_i != sel_q) || (mode_i != mode_q);

    // rise of the picked line, ignored while the configuration moves
    always_comb edge_o = line_o && !prev_q && !cfg_moved;

    // keep the previous line value and configuration for comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            sel_q  <= '0;
            mode_q <= TRIG_EDGE;
        end else begin
            prev_q <= line_o;
            sel_q  <= sel_i;
            mode_q <= mode_i;
        end
    end

    // R2
    single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

    // R8
    cfg_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_i != $past(sel_i)) || (mode_i != $past(mode_i))) |-> !edge_o);
endmodule

// File: rtl/start_arbiter.sv
// Chooses between the software strobe and the hardware trigger, then
// gates by enable, engine busy and a post-reset arming flag.
// Assumes the inputs are synchronous to clk.
module start_arbiter
    import irq_start_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       busy_i,
    input  logic       auto_i,
    input  logic       sw_start_i,
    input  trig_mode_e mode_i,
    input  logic       line_i,
    input  logic       edge_i,
    output logic       start_o
);
    logic armed_q;
    logic hw_trig;
    logic want;

    // hardware trigger according to the edge/level mode
    always_comb hw_trig = (mode_i == TRIG_LEVEL) ? line_i : edge_i;

    // source choice and gating
    always_comb want = armed_q && enable_i && !busy_i && (auto_i ? hw_trig : sw_start_i);

    // register the pulse and arm one cycle after reset release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            start_o <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            start_o <= want;
        end
    end

    // R4
    manual_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !$past(auto_i)) |-> $past(sw_start_i));

    // R6
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(enable_i));

    // R7
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !$past(busy_i));

    // R9
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |=> !start_o);
endmodule

// File: rtl/irq_start_sel.sv
// Top of the start selector: request capture, line picking with edge
// detection, and start arbitration. Output is registered.
// Assumes LINES is a power of two and all inputs are synchronous to clk.
module irq_start_sel
    import irq_start_sel_pkg::*;
#(
    parameter int LINES = DEF_LINES,
    localparam int SEL_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_req,
    input  logic [SEL_W-1:0] chan_sel,
    input  logic             level_mode,
    input  logic             auto_mode,
    input  logic             enable,
    input  logic             sw_start,
    input  logic             eng_busy,
    output logic             start_pulse
);
    logic [LINES-1:0] req_q;
    logic             line_now;
    logic             line_edge;
    trig_mode_e       mode;

    // map the mode pin onto the shared enum
    always_comb mode = level_mode ? TRIG_LEVEL : TRIG_EDGE;

    req_capture #(.W(LINES)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (irq_req),
        .req_q (req_q)
    );

    line_picker #(.LINES(LINES)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_q  (req_q),
        .sel_i  (chan_sel),
        .mode_i (mode),
        .line_o (line_now),
        .edge_o (line_edge)
    );

    start_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable),
        .busy_i     (eng_busy),
        .auto_i     (auto_mode),
        .sw_start_i (sw_start),
        .mode_i     (mode),
        .line_i     (line_now),
        .edge_i     (line_edge),
        .start_o    (start_pulse)
    );
endmodule

// File: tb/tb_irq_start_sel.sv
module tb_irq_start_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_req = '0;
    logic [3:0]  chan_sel = '0;
    logic        level_mode = 1'b0;
    logic        auto_mode = 1'b0;
    logic        enable = 1'b0;
    logic        sw_start = 1'b0;
    logic        eng_busy = 1'b0;
    logic        start_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference state derived from the requirement timing
    logic [15:0] m_irq1 = '0;
    logic        m_prev = 1'b0;
    logic [3:0]  m_sel1 = '0;
    logic        m_lvl1 = 1'b0;
    logic        m_armed = 1'b0;
    logic        exp_pulse = 1'b0;
    int          pulses = 0;

    irq_start_sel dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .chan_sel(chan_sel),
        .level_mode(level_mode), .auto_mode(auto_mode), .enable(enable),
        .sw_start(sw_start), .eng_busy(eng_busy), .start_pulse(start_pulse)
    );

    always #10 clk = ~clk;

    function automatic logic model_step();
        logic line, hw;
        line = m_irq1[chan_sel];
        if (level_mode) hw = line;
        else hw = line && !m_prev && (chan_sel == m_sel1) && (level_mode == m_lvl1);
        return m_armed && enable && !eng_busy && (auto_mode ? hw : sw_start);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: start_pulse=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: model updates at the edge, output compared at the falling edge
    task automatic tick(input string tag);
        @(posedge clk);
        if (!rst_n) begin
            exp_pulse = 1'b0;
            m_irq1 = '0; m_prev = 1'b0; m_sel1 = '0; m_lvl1 = 1'b0; m_armed = 1'b0;
        end else begin
            exp_pulse = model_step();
            m_prev = m_irq1[chan_sel];
            m_irq1 = irq_req;
            m_sel1 = chan_sel;
            m_lvl1 = level_mode;
            m_armed = 1'b1;
        end
        @(negedge clk);
        check(tag, start_pulse, exp_pulse);
        if (start_pulse === 1'b1) pulses++;
    endtask

    task automatic count_check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: pulse count=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        // R9: reset, strobe held high throughout
        enable = 1'b1; sw_start = 1'b1;
        repeat (3) tick("R9 in reset");
        rst_n = 1'b1;
        tick("R9 first cycle after reset");
        tick("R4 strobe after arming");
        sw_start = 1'b0;
        tick("R4 strobe drop");

        // R4: manual mode, request lines ignored
        irq_req = 16'hFFFF; pulses = 0;
        repeat (4) tick("R4 lines ignored in manual");
        count_check("R4 manual ignores lines", pulses, 0);
        irq_req = '0;
        repeat (3) tick("R4 settle");

        // R5: auto mode, strobe ignored
        auto_mode = 1'b1; sw_start = 1'b1; pulses = 0;
        repeat (4) tick("R5 strobe ignored");
        count_check("R5 auto ignores strobe", pulses, 0);
        sw_start = 1'b0;

        // R2 and R1: edge on line 5, held high
        chan_sel = 4'd5;
        repeat (2) tick("R8 settle select");
        irq_req[6] = 1'b1; pulses = 0;
        repeat (4) tick("R1 other line");
        count_check("R1 unselected line", pulses, 0);
        irq_req[5] = 1'b1; pulses = 0;
        tick("R2 rise sampled");
        tick("R2 pulse cycle");
        check("R2 pulse position", start_pulse, 1'b1);
        repeat (6) tick("R2 held high");
        count_check("R2 one pulse for held line", pulses, 1);

        // R8: switch to a line already high
        irq_req = 16'h0008; chan_sel = 4'd0;
        repeat (3) tick("R8 prep");
        chan_sel = 4'd3; pulses = 0;
        repeat (5) tick("R8 select high line");
        count_check("R8 no pulse on select change", pulses, 0);

        // R1: line 15 at the top of the range
        irq_req = '0; chan_sel = 4'd15;
        repeat (3) tick("R1 prep");
        irq_req[15] = 1'b1; pulses = 0;
        repeat (4) tick("R1 line 15");
        count_check("R1 line 15 selected", pulses, 1);

        // R3: level mode, four high cycles give four pulses
        irq_req = '0; level_mode = 1'b1;
        repeat (3) tick("R3 prep");
        irq_req[15] = 1'b1; pulses = 0;
        repeat (4) tick("R3 high");
        irq_req[15] = 1'b0;
        repeat (4) tick("R3 low");
        count_check("R3 level pulses", pulses, 4);

        // R6 and R7: gating in level mode
        irq_req[15] = 1'b1; enable = 1'b0; pulses = 0;
        repeat (4) tick("R6 disabled");
        count_check("R6 enable gate", pulses, 0);
        enable = 1'b1; eng_busy = 1'b1;
        repeat (4) tick("R7 busy");
        count_check("R7 busy gate", pulses, 0);
        eng_busy = 1'b0; irq_req = '0;
        repeat (3) tick("R7 settle");

        // random mix over all requirements
        for (int i = 0; i < 4000; i++) begin
            irq_req = irq_req ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
            if ($urandom_range(15) == 0) chan_sel = 4'($urandom);
            if ($urandom_range(31) == 0) level_mode = ~level_mode;
            if ($urandom_range(15) == 0) auto_mode = ~auto_mode;
            enable = ($urandom_range(9) != 0);
            eng_busy = ($urandom_range(3) == 0);
            sw_start = ($urandom_range(3) == 0);
            if ($urandom_range(999) == 0) rst_n = 1'b0;
            else rst_n = 1'b1;
            tick("random R1 R2 R3 R4 R5 R6 R7 R8 R9");
        end
        summary();
    end
endmodule